// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block is a control-port slave for a two-wire serial bus. An external host reaches an internal bank of byte-wide registers through it. The block runs on a fast system clock and oversamples both bus lines through synchronizers. It drives the data line only by pulling it low, through an output-enable signal. Two strap inputs choose the two low bits of the device address. These straps are captured only while reset is held.

A write transaction sends the device address with the direction bit clear. The next byte loads an internal register pointer. Each further byte is stored at the pointer, and the pointer then advances by one. A read transaction sends the device address with the direction bit set. The slave then shifts out registers from the current pointer, most significant bit first, and advances after every byte the host acknowledges.

A read carries no pointer of its own. The host therefore loads the pointer with a write that it ends by a STOP straight after the pointer byte, and then starts a separate read. The rest of the chip sees the same registers through a plain parallel port: a combinational read and a single-cycle write strobe.

Top module: `i2c_reg_slave`

## Requirements
- R1: Out of reset the port releases the data line, the pointer is 0 and every register reads 0 through the parallel port.
- R2: After a START (data falling while clock is high), a first byte whose upper seven bits equal 1,0,0,1,1 followed by the latched strap bits (strap bit 1 then strap bit 0) is acknowledged by a low data line during the ninth clock high. The lowest bit of that byte is the direction: 1 for read, 0 for write.
- R3: A first byte with any other address gets no acknowledge, and the data bytes that follow it change no register.
- R4: The strap inputs are sampled only while reset is asserted; changing them later leaves the matched address unchanged.
- R5: In a write, the second byte sets the pointer and each following byte is stored at the pointer, which then advances by one.
- R6: The pointer keeps its low five bits (32 registers) and wraps from 31 to 0 on writes and on reads.
- R7: A STOP right after the acknowledged pointer byte changes no register, keeps the new pointer, and releases the data line.
- R8: In a read, each register byte is shifted out most significant bit first, starting at the current pointer.
- R9: When the host does not acknowledge a transmitted byte, the slave releases the line and the pointer stays on that byte, so the next read returns it again.
- R10: A repeated START is handled exactly like a START, including straight after an unmatched address.
- R11: A parallel-port write stores a byte that a later bus read returns, and the parallel read shows every register's contents.
- R12: The slave acknowledges every pointer and data byte it receives, and releases the data line after the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset; the straps are captured while it is low |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls the data line low; 0 releases it |
| strapAddr | input | 2 | Low two device-address bits (bit 1, bit 0) |
| hostAddr | input | $clog2(NREGS) | Parallel-port register index |
| hostWe | input | 1 | Parallel-port write strobe |
| hostWdata | input | 8 | Parallel-port write data |
| hostRdata | output | 8 | Register contents at hostAddr |

## Verification
The device address is swept through all 128 seven-bit values. This shows that only the prefix plus the latched straps is acknowledged, and that straps changed after reset do not take part. Data patterns that differ from register to register are written as one block across the whole bank and as a short burst that crosses the wrap. Each byte therefore shows both where it landed and the order of its bits. Reads are tried in several forms: a long acknowledged burst, a burst ended by a not-acknowledge and then re-read, a repeated START without a STOP, and an aborted pointer write. These separate the pointer-advance rules from the data path.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } ctrlState_t;

  // Bus events seen by the datapath, handed to the control
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
    logic lastBit;
    logic addrHit;
  } busEvt_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic sdaRelease;
  } ctrlStb_t;

endpackage

// File: rtl/i2c_reg_sync.sv
module i2c_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int         NREGS       = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  input  logic [1:0]               strapAddr,
  input  ctrlStb_t                 stb,
  output busEvt_t                  evt,
  output logic                     sdaOe,
  input  logic [$clog2(NREGS)-1:0] hostAddr,
  input  logic                     hostWe,
  input  logic [BYTE_W-1:0]        hostWdata,
  output logic [BYTE_W-1:0]        hostRdata
);

  localparam int PTR_W = $clog2(NREGS);

  logic sclSync, sdaSync, sclPrev, sdaPrev;
  logic [1:0]          strapQ;
  logic [BYTE_W-2:0]   rxReg;
  logic [BYTE_W-1:0]   rxByte;
  logic [CNT_W-1:0]    bitCnt;
  logic [PTR_W-1:0]    ptr;
  logic [BYTE_W-1:0]   txReg;
  logic [BYTE_W-1:0]   regBank [NREGS];

  i2c_reg_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync)
  );
  i2c_reg_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  // Straps captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapAddr;
  end

  assign rxByte = {rxReg, sdaSync};

  always_comb begin
    evt         = '0;
    evt.start   = sclSync && sclPrev && sdaPrev && !sdaSync;
    evt.stop    = sclSync && sclPrev && !sdaPrev && sdaSync;
    evt.sclRise = sclSync && !sclPrev;
    evt.sclFall = !sclSync && sclPrev;
    evt.sdaBit  = sdaSync;
    evt.lastBit = (bitCnt == CNT_W'(BYTE_W - 1));
    evt.addrHit = (rxReg == {ADDR_PREFIX, strapQ});
  end

  // Receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      bitCnt <= '0;
    end else if (stb.clrCnt) begin
      bitCnt <= '0;
    end else if (stb.shiftIn) begin
      rxReg  <= rxByte[BYTE_W-2:0];
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Register pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= '0;
    else if (stb.loadPtr) ptr <= rxByte[PTR_W-1:0];
    else if (stb.incPtr)  ptr <= ptr + 1'b1;
  end

  // Register bank: bus write wins over a same-cycle parallel write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regBank[i] <= '0;
    end else if (stb.writeReg) begin
      regBank[ptr] <= rxByte;
    end else if (hostWe) begin
      regBank[hostAddr] <= hostWdata;
    end
  end

  assign hostRdata = regBank[hostAddr];

  // Transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txReg <= '0;
    else if (stb.loadTx)  txReg <= regBank[ptr];
    else if (stb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b0};
  end

  // Open-drain enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sdaOe <= 1'b0;
    else if (stb.sdaRelease) sdaOe <= 1'b0;
    else if (stb.ackOn)      sdaOe <= 1'b1;
    else if (stb.loadTx)     sdaOe <= ~regBank[ptr][BYTE_W-1];
    else if (stb.shiftTx)    sdaOe <= ~txReg[BYTE_W-2];
  end

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busEvt_t  evt,
  output ctrlStb_t stb
);

  ctrlState_t state, nxtState;
  logic rw, nxtRw;
  logic ackPh, nxtPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rw    <= 1'b0;
      ackPh <= 1'b0;
    end else begin
      state <= nxtState;
      rw    <= nxtRw;
      ackPh <= nxtPh;
    end
  end

  always_comb begin
    nxtState = state;
    nxtRw    = rw;
    nxtPh    = ackPh;
    stb      = '0;
    if (evt.start) begin
      nxtState       = ST_ADDR;
      nxtPh          = 1'b0;
      stb.clrCnt     = 1'b1;
      stb.sdaRelease = 1'b1;
    end else if (evt.stop) begin
      nxtState       = ST_IDLE;
      nxtPh          = 1'b0;
      stb.sdaRelease = 1'b1;
    end else begin
      case (state)
        ST_ADDR: begin
          if (evt.sclRise) begin
            stb.shiftIn = 1'b1;
            if (evt.lastBit) begin
              if (evt.addrHit) begin
                nxtRw    = evt.sdaBit;
                nxtState = ST_ADDR_ACK;
                nxtPh    = 1'b0;
              end else begin
                nxtState = ST_SKIP;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            if (!ackPh) begin
              stb.ackOn = 1'b1;
              nxtPh     = 1'b1;
            end else begin
              nxtPh      = 1'b0;
              stb.clrCnt = 1'b1;
              if (rw) begin
                stb.loadTx = 1'b1;
                nxtState   = ST_RDATA;
              end else begin
                stb.sdaRelease = 1'b1;
                nxtState       = ST_PTR;
              end
            end
          end
        end
        ST_PTR: begin
          if (evt.sclRise) begin
            stb.shiftIn = 1'b1;
            if (evt.lastBit) begin
              stb.loadPtr = 1'b1;
              nxtState    = ST_PTR_ACK;
            end
          end
        end
        ST_WDATA: begin
          if (evt.sclRise) begin
            stb.shiftIn = 1'b1;
            if (evt.lastBit) begin
              stb.writeReg = 1'b1;
              stb.incPtr   = 1'b1;
              nxtState     = ST_WDATA_ACK;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (evt.sclFall) begin
            if (!ackPh) begin
              stb.ackOn = 1'b1;
              nxtPh     = 1'b1;
            end else begin
              nxtPh          = 1'b0;
              stb.clrCnt     = 1'b1;
              stb.sdaRelease = 1'b1;
              nxtState       = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (evt.sclFall) begin
            stb.shiftTx = 1'b1;
          end else if (evt.sclRise) begin
            stb.shiftIn = 1'b1;
            if (evt.lastBit) nxtState = ST_RACK;
          end
        end
        ST_RACK: begin
          if (evt.sclFall) begin
            if (!ackPh) begin
              stb.sdaRelease = 1'b1;
            end else begin
              stb.loadTx = 1'b1;
              stb.clrCnt = 1'b1;
              nxtPh      = 1'b0;
              nxtState   = ST_RDATA;
            end
          end else if (evt.sclRise && !ackPh) begin
            if (evt.sdaBit) begin
              nxtState = ST_SKIP;
            end else begin
              stb.incPtr = 1'b1;
              nxtPh      = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int         NREGS       = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaOe,
  input  logic [1:0]               strapAddr,
  input  logic [$clog2(NREGS)-1:0] hostAddr,
  input  logic                     hostWe,
  input  logic [7:0]               hostWdata,
  output logic [7:0]               hostRdata
);

  busEvt_t  evt;
  ctrlStb_t stb;

  i2c_reg_dp #(
    .NREGS(NREGS), .SYNC_STAGES(SYNC_STAGES), .ADDR_PREFIX(ADDR_PREFIX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapAddr(strapAddr), .stb(stb), .evt(evt), .sdaOe(sdaOe),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata),
    .hostRdata(hostRdata)
  );

  i2c_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .stb(stb)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_reg_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input busEvt_t  evt,
  input ctrlStb_t stb,
  input logic     sdaOe
);

  // R12
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackOn |=> sdaOe);

  // R2
  oe_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(stb.ackOn || stb.loadTx || stb.shiftTx));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> !sdaOe);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.start |=> !sdaOe);

  // R5
  write_on_eighth_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeReg |-> (evt.sclRise && evt.lastBit));

  // R6
  ptr_single_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadPtr, stb.incPtr}));

  // R8
  tx_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx || stb.shiftTx) |-> evt.sclFall);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .evt(evt), .stb(stb), .sdaOe(sdaOe)
);

// File: tb/i2c_reg_slave_bench.sv
`timescale 1ns/1ps
module i2c_reg_slave_bench;

  localparam int Q = 8;
  localparam int NR = 32;
  localparam logic [6:0] ADDR_OK = 7'b1001110;  // prefix + strap 2'b10

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msScl = 1'b1, msSda = 1'b1;
  logic sdaLine, sdaOe;
  logic [1:0] strapAddr = 2'b10;
  logic [4:0] hostAddr = '0;
  logic hostWe = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;
  logic [7:0] model [NR];
  int modelPtr = 0;
  logic [7:0] wbuf [64];

  always #2.5 clk = ~clk;
  assign sdaLine = msSda & ~sdaOe;

  i2c_reg_slave u_i2c_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(msScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapAddr(strapAddr), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startC();
    msSda = 1'b1; waitQ(1);
    msScl = 1'b1; waitQ(1);
    msSda = 1'b0; waitQ(1);
    msScl = 1'b0; waitQ(1);
  endtask

  task automatic stopC();
    msSda = 1'b0; waitQ(1);
    msScl = 1'b1; waitQ(1);
    msSda = 1'b1; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit chkRel, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msSda = b[i]; waitQ(1);
      msScl = 1'b1; waitQ(2);
      msScl = 1'b0; waitQ(1);
    end
    msSda = 1'b1; waitQ(1);
    msScl = 1'b1; waitQ(1);
    ack = (sdaLine == 1'b0);
    waitQ(1);
    msScl = 1'b0; waitQ(1);
    if (chkRel && ack) chk("R12 release after ninth clock", sdaOe, 0);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] d);
    msSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      msScl = 1'b1; waitQ(1);
      d[i] = sdaLine;
      waitQ(1);
      msScl = 1'b0;
    end
    waitQ(1);
    msSda = nack; waitQ(1);
    msScl = 1'b1; waitQ(2);
    msScl = 1'b0; waitQ(1);
    msSda = 1'b1;
  endtask

  task automatic hostRead(input int a, output logic [7:0] d);
    hostAddr = a[4:0];
    @(negedge clk);
    d = hostRdata;
  endtask

  task automatic compareBank(input string tag);
    logic [7:0] d;
    for (int i = 0; i < NR; i++) begin
      hostRead(i, d);
      chk(tag, d, model[i]);
    end
  endtask

  task automatic i2cWrite(input logic [7:0] p, input int n);
    bit ack;
    startC();
    sendByte({ADDR_OK, 1'b0}, 1'b1, ack); chk("R2 address ack", ack, 1);
    sendByte(p, 1'b1, ack);               chk("R12 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], 1'b1, ack);       chk("R5 data ack", ack, 1);
      model[(p + i) % NR] = wbuf[i];
    end
    stopC();
    modelPtr = (p + n) % NR;
  endtask

  task automatic setPtr(input logic [7:0] p);
    bit ack;
    startC();
    sendByte({ADDR_OK, 1'b0}, 1'b1, ack); chk("R7 address ack", ack, 1);
    sendByte(p, 1'b1, ack);               chk("R7 pointer ack", ack, 1);
    stopC();
    modelPtr = p % NR;
  endtask

  task automatic i2cRead(input int n, input string tag);
    bit ack;
    logic [7:0] d;
    startC();
    sendByte({ADDR_OK, 1'b1}, 1'b0, ack); chk("R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, d);
      chk(tag, d, model[(modelPtr + i) % NR]);
    end
    stopC();
    chk("R9 released after nack", sdaOe, 0);
    modelPtr = (modelPtr + n - 1) % NR;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    strapAddr = 2'b01;  // R4: too late to matter

    // R1 reset state
    chk("R1 sda released", sdaOe, 0);
    compareBank("R1 register reset value");

    // R2 R3 R4 full address sweep
    for (int a = 0; a < 128; a++) begin
      startC();
      sendByte({a[6:0], 1'b0}, 1'b0, ack);
      stopC();
      if (a == int'(ADDR_OK))            chk("R4 latched strap acked", ack, 1);
      else if (a == int'(7'b1001101))    chk("R4 late strap ignored", ack, 0);
      else                               chk("R2 R3 address match", ack, (a == int'(ADDR_OK)) ? 1 : 0);
    end
    compareBank("R3 sweep changed nothing");

    // R3 mismatch followed by data
    startC();
    sendByte(8'b1001111_0, 1'b0, ack); chk("R3 mismatch no ack", ack, 0);
    sendByte(8'h05, 1'b0, ack);        chk("R3 ignored byte no ack", ack, 0);
    sendByte(8'hAA, 1'b0, ack);        chk("R3 ignored data no ack", ack, 0);
    stopC();
    compareBank("R3 no register written");

    // R5 block write of whole bank
    for (int i = 0; i < NR; i++) wbuf[i] = 8'((i * 37 + 5) & 255);
    i2cWrite(8'h00, NR);
    compareBank("R5 block write");

    // R6 wrap on write, upper pointer bits ignored
    for (int i = 0; i < 4; i++) wbuf[i] = 8'((i * 11 + 8'h80) & 255);
    i2cWrite(8'hFE, 4);
    compareBank("R6 write wrap 31 to 0");

    // R7 aborted write only loads pointer
    setPtr(8'd7);
    compareBank("R7 no register changed");
    i2cRead(3, "R8 read from loaded pointer");

    // R8 long read from 0
    setPtr(8'd0);
    i2cRead(NR, "R8 full bank read MSB first");
    // R9 nacked byte re-read, R6 read wrap
    i2cRead(3, "R9 R6 reread and wrap");

    // R10 repeated start between pointer write and read
    startC();
    sendByte({ADDR_OK, 1'b0}, 1'b1, ack); chk("R10 address ack", ack, 1);
    sendByte(8'd12, 1'b1, ack);           chk("R10 pointer ack", ack, 1);
    startC();
    sendByte({ADDR_OK, 1'b1}, 1'b0, ack); chk("R10 read address ack", ack, 1);
    recvByte(1'b0, d); chk("R10 byte 12", d, model[12]);
    recvByte(1'b1, d); chk("R10 byte 13", d, model[13]);
    stopC();

    // R10 repeated start after mismatch
    startC();
    sendByte(8'b0001110_0, 1'b0, ack);    chk("R3 wrong prefix no ack", ack, 0);
    startC();
    sendByte({ADDR_OK, 1'b0}, 1'b1, ack); chk("R10 ack after mismatch", ack, 1);
    sendByte(8'd3, 1'b1, ack);            chk("R10 pointer ack", ack, 1);
    sendByte(8'h77, 1'b1, ack);           chk("R10 data ack", ack, 1);
    stopC();
    model[3] = 8'h77;
    compareBank("R10 write after repeated start");

    // R11 parallel write read back over the bus
    hostAddr = 5'd20; hostWdata = 8'h5A; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
    model[20] = 8'h5A;
    hostRead(20, d); chk("R11 parallel readback", d, 8'h5A);
    setPtr(8'd20);
    i2cRead(1, "R11 bus read of parallel write");

    // R4 new reset latches new strap
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    compareBank("R1 registers cleared by reset");
    startC();
    sendByte(8'b1001101_0, 1'b0, ack); chk("R4 new strap acked", ack, 1);
    stopC();
    startC();
    sendByte({ADDR_OK, 1'b0}, 1'b0, ack); chk("R4 old strap ignored", ack, 0);
    stopC();

    done = 1'b1;
    report();
    $finish;
  end

endmodule